// File: doc/BRIEF.md
# Clock Output Mode Selector

This block decides what every clock pin of a clock generator carries. It reads a four-bit control field. Bits 1:0 hold the operating mode. Bits 3:2 choose, for each of the two USB-rate outputs, between the 48 MHz and the 24 MHz source. The block then drives a clock level and an output enable for every output.

The block covers four output groups. In the normal and spread modes the CPU, SDRAM, PCI, reference, I/O-APIC and USB-rate outputs follow the generated clocks. The PCI rate is derived here as half the CPU rate. In spread mode the block also raises a flag that tells the frequency generator to modulate. In test mode every output is taken from a test clock that arrives on the crystal pin. Each output class has a fixed divide ratio of 1, 2 or 4. In the high-impedance mode every enable is released.

All clock inputs are treated as levels and sampled with the fast system clock `clk_i`. Every output is registered, so the output pins change a fixed number of cycles after the input pins.

Top module: `clk_mode_sel`

## Requirements
- R1: `cfg_i[1:0]` selects the operating mode: 00 normal, 01 test, 10 spread, 11 high-impedance. A value presented before clock edge k and the clock samples taken at edge k appear together on the outputs after edge k+1.
- R2: In high-impedance mode every output enable is low and every clock output is held low.
- R3: In normal, test and spread modes every output enable is high.
- R4: `ss_en_o` is high in spread mode and low in every other mode. Spread mode routes the clocks exactly as normal mode does.
- R5: In normal and spread modes the CPU and SDRAM outputs carry the sampled CPU input. The PCI outputs carry half the CPU rate: PCI is high after an odd number of CPU rising samples since reset, so each PCI rise lands on a CPU rise.
- R6: In normal and spread modes the reference and I/O-APIC outputs carry the sampled reference input.
- R7: USB-rate output j is controlled by `cfg_i[2+j]`: 1 selects the 48 MHz source and 0 selects the 24 MHz source. This applies in every mode that drives the outputs.
- R8: In test mode the reference and I/O-APIC outputs carry the sampled test clock undivided.
- R9: In test mode the CPU and SDRAM outputs, and any USB-rate output set to 48 MHz, carry the test clock divided by 2.
- R10: In test mode the PCI outputs, and any USB-rate output set to 24 MHz, carry the test clock divided by 4.
- R11: When the mode changes into test from any other mode, the test dividers are cleared. The divide-by-2 and divide-by-4 outputs stay low until the next test-clock rising sample, and then both go high together. A rise sampled in the same cycle as the change into test is discarded.
- R12: While `rst_ni` is low all clock outputs, output enables and `ss_en_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_i | input | 4 | Mode in [1:0], USB-rate selects in [3:2] |
| tclk_i | input | 1 | Test clock from the crystal input |
| cpu_clk_i | input | 1 | Generated CPU-rate clock |
| ref_clk_i | input | 1 | Reference oscillator clock |
| clk48_i | input | 1 | 48 MHz source |
| clk24_i | input | 1 | 24 MHz source |
| cpu_clk_o | output | 4 | CPU clock outputs |
| cpu_oe_o | output | 4 | CPU output enables |
| pci_clk_o | output | 7 | PCI clock outputs, including the free-running one |
| pci_oe_o | output | 7 | PCI output enables |
| sdr_clk_o | output | 8 | SDRAM clock outputs |
| sdr_oe_o | output | 8 | SDRAM output enables |
| ref_clk_o | output | 3 | Reference clock outputs |
| ref_oe_o | output | 3 | Reference output enables |
| apic_clk_o | output | 1 | I/O-APIC clock output |
| apic_oe_o | output | 1 | I/O-APIC output enable |
| usb_clk_o | output | 2 | 48/24 MHz clock outputs |
| usb_oe_o | output | 2 | 48/24 MHz output enables |
| ss_en_o | output | 1 | Spread enable to the frequency generator |

## Verification
Some properties are checked by assertions on every cycle:
- high-impedance mode leaves every pin quiet and undriven;
- the driving modes enable every pin;
- the spread flag follows the mode;
- SDRAM tracks CPU in the generated-clock modes;
- a divider clear always yields low divided outputs;
- a divide-by-4 rise never occurs without a divide-by-2 rise.

Other behaviour can only be shown by the bench's scenarios, which compare every output group against waveforms worked out from the stimulus:
- the exact divided waveforms in test mode;
- the PCI phase relative to the CPU input;
- the per-output 48/24 choice;
- the two-cycle latency;
- the discarded rise when test mode is re-entered part-way through a divide cycle.

// File: rtl/clk_mode_pkg.sv
package clk_mode_pkg;

  localparam int CFG_W  = 4;
  localparam int MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    OPM_NORMAL = 2'b00,
    OPM_TEST   = 2'b01,
    OPM_SPREAD = 2'b10,
    OPM_HIZ    = 2'b11
  } opm_e;

  typedef struct packed {
    logic d1;
    logic d2;
    logic d4;
  } div_taps_t;

endpackage

// File: rtl/clk_edge_div.sv
module clk_edge_div
  import clk_mode_pkg::*;
#(
  parameter int DIV_LOG2 = 2
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      src_i,
  input  logic      clr_i,
  output div_taps_t taps_o
);

  localparam int CNT_W = DIV_LOG2;

  logic             src_q;
  logic [CNT_W-1:0] cnt_q;
  logic             rise;

  assign rise = src_i & ~src_q;

  // preset to all ones so the first counted rise lands on zero: both taps go high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q <= 1'b0;
      cnt_q <= '1;
    end else begin
      src_q <= src_i;
      if (clr_i)     cnt_q <= '1;
      else if (rise) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign taps_o.d1 = src_q;
  assign taps_o.d2 = ~cnt_q[0];
  assign taps_o.d4 = ~cnt_q[CNT_W-1];

  // R11
  div_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (!taps_o.d2 && !taps_o.d4));

  // R11
  div_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(taps_o.d4) |-> $rose(taps_o.d2));

  // R9
  div_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rise && !clr_i) |=> $stable(taps_o.d2));

endmodule

// File: rtl/clk_mode_ctrl.sv
module clk_mode_ctrl
  import clk_mode_pkg::*;
#(
  parameter int              N_SEL   = 2,
  parameter int              SEL_LSB = 2,
  parameter logic [N_SEL-1:0] SEL_RST = '1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [SEL_LSB+N_SEL-1:0] cfg_i,
  output opm_e                     mode_o,
  output logic [N_SEL-1:0]         sel_o,
  output logic                     test_entry_o
);

  opm_e             mode_q;
  opm_e             mode_d;
  logic [N_SEL-1:0] sel_q;

  assign mode_d       = opm_e'(cfg_i[MODE_W-1:0]);
  assign test_entry_o = (mode_d == OPM_TEST) && (mode_q != OPM_TEST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= OPM_NORMAL;
      sel_q  <= SEL_RST;
    end else begin
      mode_q <= mode_d;
      sel_q  <= cfg_i[SEL_LSB +: N_SEL];
    end
  end

  assign mode_o = mode_q;
  assign sel_o  = sel_q;

  // R11
  entry_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    test_entry_o |=> (mode_o == OPM_TEST));

endmodule

// File: rtl/clk_out_route.sv
module clk_out_route
  import clk_mode_pkg::*;
#(
  parameter int N_CPU  = 4,
  parameter int N_PCI  = 7,
  parameter int N_SDR  = 8,
  parameter int N_REF  = 3,
  parameter int N_APIC = 1,
  parameter int N_USB  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  opm_e              mode_i,
  input  logic [N_USB-1:0]  sel_i,
  input  div_taps_t         tdiv_i,
  input  div_taps_t         cdiv_i,
  input  logic              ref_i,
  input  logic              c48_i,
  input  logic              c24_i,
  output logic [N_CPU-1:0]  cpu_clk_o,
  output logic [N_CPU-1:0]  cpu_oe_o,
  output logic [N_PCI-1:0]  pci_clk_o,
  output logic [N_PCI-1:0]  pci_oe_o,
  output logic [N_SDR-1:0]  sdr_clk_o,
  output logic [N_SDR-1:0]  sdr_oe_o,
  output logic [N_REF-1:0]  ref_clk_o,
  output logic [N_REF-1:0]  ref_oe_o,
  output logic [N_APIC-1:0] apic_clk_o,
  output logic [N_APIC-1:0] apic_oe_o,
  output logic [N_USB-1:0]  usb_clk_o,
  output logic [N_USB-1:0]  usb_oe_o,
  output logic              ss_o
);

  logic             cpu_n, pci_n, sdr_n, ref_n, apic_n, drv_n, ss_n;
  logic [N_USB-1:0] usb_n, usb_norm, usb_test;

  for (genvar j = 0; j < N_USB; j++) begin : g_usb
    assign usb_norm[j] = sel_i[j] ? c48_i     : c24_i;
    assign usb_test[j] = sel_i[j] ? tdiv_i.d2 : tdiv_i.d4;
  end

  always_comb begin
    cpu_n  = 1'b0;
    pci_n  = 1'b0;
    sdr_n  = 1'b0;
    ref_n  = 1'b0;
    apic_n = 1'b0;
    usb_n  = '0;
    drv_n  = 1'b0;
    ss_n   = 1'b0;
    unique case (mode_i)
      OPM_NORMAL, OPM_SPREAD: begin
        cpu_n  = cdiv_i.d1;
        sdr_n  = cdiv_i.d1;
        pci_n  = cdiv_i.d2;
        ref_n  = ref_i;
        apic_n = ref_i;
        usb_n  = usb_norm;
        drv_n  = 1'b1;
        ss_n   = (mode_i == OPM_SPREAD);
      end
      OPM_TEST: begin
        ref_n  = tdiv_i.d1;
        apic_n = tdiv_i.d1;
        cpu_n  = tdiv_i.d2;
        sdr_n  = tdiv_i.d2;
        pci_n  = tdiv_i.d4;
        usb_n  = usb_test;
        drv_n  = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cpu_clk_o  <= '0;
      cpu_oe_o   <= '0;
      pci_clk_o  <= '0;
      pci_oe_o   <= '0;
      sdr_clk_o  <= '0;
      sdr_oe_o   <= '0;
      ref_clk_o  <= '0;
      ref_oe_o   <= '0;
      apic_clk_o <= '0;
      apic_oe_o  <= '0;
      usb_clk_o  <= '0;
      usb_oe_o   <= '0;
      ss_o       <= 1'b0;
    end else begin
      cpu_clk_o  <= {N_CPU{cpu_n}};
      cpu_oe_o   <= {N_CPU{drv_n}};
      pci_clk_o  <= {N_PCI{pci_n}};
      pci_oe_o   <= {N_PCI{drv_n}};
      sdr_clk_o  <= {N_SDR{sdr_n}};
      sdr_oe_o   <= {N_SDR{drv_n}};
      ref_clk_o  <= {N_REF{ref_n}};
      ref_oe_o   <= {N_REF{drv_n}};
      apic_clk_o <= {N_APIC{apic_n}};
      apic_oe_o  <= {N_APIC{drv_n}};
      usb_clk_o  <= usb_n;
      usb_oe_o   <= {N_USB{drv_n}};
      ss_o       <= ss_n;
    end
  end

  // R2
  hiz_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == OPM_HIZ) |=> (cpu_oe_o == '0 && pci_oe_o == '0 && sdr_oe_o == '0 &&
                             ref_oe_o == '0 && apic_oe_o == '0 && usb_oe_o == '0 &&
                             cpu_clk_o == '0 && pci_clk_o == '0 && sdr_clk_o == '0 &&
                             ref_clk_o == '0 && apic_clk_o == '0 && usb_clk_o == '0));

  // R3
  drive_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != OPM_HIZ) |=> (&cpu_oe_o && &pci_oe_o && &sdr_oe_o &&
                             &ref_oe_o && &apic_oe_o && &usb_oe_o));

  // R4
  ss_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == OPM_SPREAD) |=> ss_o);

  // R4
  ss_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != OPM_SPREAD) |=> !ss_o);

  // R5
  sdr_track_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == OPM_NORMAL || mode_i == OPM_SPREAD) |=> (sdr_clk_o == {N_SDR{cpu_clk_o[0]}}));

endmodule

// File: rtl/clk_mode_sel.sv
module clk_mode_sel
  import clk_mode_pkg::*;
#(
  parameter int N_CPU    = 4,
  parameter int N_PCI    = 7,
  parameter int N_SDR    = 8,
  parameter int N_REF    = 3,
  parameter int N_APIC   = 1,
  parameter int N_USB    = 2,
  parameter int DIV_LOG2 = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [MODE_W+N_USB-1:0]   cfg_i,
  input  logic                      tclk_i,
  input  logic                      cpu_clk_i,
  input  logic                      ref_clk_i,
  input  logic                      clk48_i,
  input  logic                      clk24_i,
  output logic [N_CPU-1:0]          cpu_clk_o,
  output logic [N_CPU-1:0]          cpu_oe_o,
  output logic [N_PCI-1:0]          pci_clk_o,
  output logic [N_PCI-1:0]          pci_oe_o,
  output logic [N_SDR-1:0]          sdr_clk_o,
  output logic [N_SDR-1:0]          sdr_oe_o,
  output logic [N_REF-1:0]          ref_clk_o,
  output logic [N_REF-1:0]          ref_oe_o,
  output logic [N_APIC-1:0]         apic_clk_o,
  output logic [N_APIC-1:0]         apic_oe_o,
  output logic [N_USB-1:0]          usb_clk_o,
  output logic [N_USB-1:0]          usb_oe_o,
  output logic                      ss_en_o
);

  opm_e             mode;
  logic [N_USB-1:0] sel;
  logic             test_entry;
  div_taps_t        tdiv, cdiv;
  logic             ref_q, c48_q, c24_q;

  // match the one-cycle sampling latency of the dividers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q <= 1'b0;
      c48_q <= 1'b0;
      c24_q <= 1'b0;
    end else begin
      ref_q <= ref_clk_i;
      c48_q <= clk48_i;
      c24_q <= clk24_i;
    end
  end

  clk_mode_ctrl #(
    .N_SEL   (N_USB),
    .SEL_LSB (MODE_W),
    .SEL_RST ({N_USB{1'b1}})
  ) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cfg_i        (cfg_i),
    .mode_o       (mode),
    .sel_o        (sel),
    .test_entry_o (test_entry)
  );

  clk_edge_div #(.DIV_LOG2(DIV_LOG2)) u_tdiv (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .src_i  (tclk_i),
    .clr_i  (test_entry),
    .taps_o (tdiv)
  );

  clk_edge_div #(.DIV_LOG2(DIV_LOG2)) u_cdiv (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .src_i  (cpu_clk_i),
    .clr_i  (1'b0),
    .taps_o (cdiv)
  );

  clk_out_route #(
    .N_CPU (N_CPU),
    .N_PCI (N_PCI),
    .N_SDR (N_SDR),
    .N_REF (N_REF),
    .N_APIC(N_APIC),
    .N_USB (N_USB)
  ) u_route (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_i     (mode),
    .sel_i      (sel),
    .tdiv_i     (tdiv),
    .cdiv_i     (cdiv),
    .ref_i      (ref_q),
    .c48_i      (c48_q),
    .c24_i      (c24_q),
    .cpu_clk_o  (cpu_clk_o),
    .cpu_oe_o   (cpu_oe_o),
    .pci_clk_o  (pci_clk_o),
    .pci_oe_o   (pci_oe_o),
    .sdr_clk_o  (sdr_clk_o),
    .sdr_oe_o   (sdr_oe_o),
    .ref_clk_o  (ref_clk_o),
    .ref_oe_o   (ref_oe_o),
    .apic_clk_o (apic_clk_o),
    .apic_oe_o  (apic_oe_o),
    .usb_clk_o  (usb_clk_o),
    .usb_oe_o   (usb_oe_o),
    .ss_o       (ss_en_o)
  );

endmodule

// File: tb/clk_mode_sel_bench.sv
module clk_mode_sel_bench;

  localparam int NC = 4, NP = 7, NS = 8, NR = 3, NA = 1, NU = 2;
  localparam int ROW_STEPS = 12;
  // stimulus table: cfg value per row; each test row follows a non-test row
  localparam logic [3:0] ROWS [8] = '{4'b0000, 4'b1100, 4'b0101, 4'b1010,
                                      4'b0011, 4'b1001, 4'b0110, 4'b0001};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [3:0] cfg_i = '0;
  logic tclk_i = 1'b0, cpu_i = 1'b0, ref_i = 1'b0, c48_i = 1'b0, c24_i = 1'b0;
  logic [NC-1:0] cpu_clk_o, cpu_oe_o;
  logic [NP-1:0] pci_clk_o, pci_oe_o;
  logic [NS-1:0] sdr_clk_o, sdr_oe_o;
  logic [NR-1:0] ref_clk_o, ref_oe_o;
  logic [NA-1:0] apic_clk_o, apic_oe_o;
  logic [NU-1:0] usb_clk_o, usb_oe_o;
  logic ss_en_o;

  clk_mode_sel u_clk_mode_sel (
    .clk_i(clk), .rst_ni(rst_n), .cfg_i(cfg_i), .tclk_i(tclk_i),
    .cpu_clk_i(cpu_i), .ref_clk_i(ref_i), .clk48_i(c48_i), .clk24_i(c24_i),
    .cpu_clk_o(cpu_clk_o), .cpu_oe_o(cpu_oe_o), .pci_clk_o(pci_clk_o), .pci_oe_o(pci_oe_o),
    .sdr_clk_o(sdr_clk_o), .sdr_oe_o(sdr_oe_o), .ref_clk_o(ref_clk_o), .ref_oe_o(ref_oe_o),
    .apic_clk_o(apic_clk_o), .apic_oe_o(apic_oe_o), .usb_clk_o(usb_clk_o), .usb_oe_o(usb_oe_o),
    .ss_en_o(ss_en_o)
  );

  int n_chk = 0, n_bad = 0;
  logic [31:0] g = '0;
  int n_cpu = 0, m_t = 0;
  logic prev_cpu = 1'b0, prev_t = 1'b0;
  logic [1:0] prev_mode = 2'b00;
  // expected word: [0]cpu [1]pci [2]sdr [3]ref [4]apic [6:5]usb [7]oe [8]ss
  logic [8:0] exp_q1 = '0, exp_q2 = '0;
  logic v1 = 1'b0, v2 = 1'b0;
  string tag_q1 = "", tag_q2 = "";

  task automatic compare(input logic [8:0] e, input string tag);
    logic ok;
    ok = (cpu_clk_o == {NC{e[0]}}) && (pci_clk_o == {NP{e[1]}}) && (sdr_clk_o == {NS{e[2]}}) &&
         (ref_clk_o == {NR{e[3]}}) && (apic_clk_o == {NA{e[4]}}) && (usb_clk_o == e[6:5]) &&
         (cpu_oe_o == {NC{e[7]}}) && (pci_oe_o == {NP{e[7]}}) && (sdr_oe_o == {NS{e[7]}}) &&
         (ref_oe_o == {NR{e[7]}}) && (apic_oe_o == {NA{e[7]}}) && (usb_oe_o == {NU{e[7]}}) &&
         (ss_en_o == e[8]);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s step %0d: cpu=%b pci=%b sdr=%b ref=%b apic=%b usb=%b oe=%b%b%b%b%b%b ss=%b expected word=%b",
               tag, g, cpu_clk_o, pci_clk_o, sdr_clk_o, ref_clk_o, apic_clk_o, usb_clk_o,
               cpu_oe_o, pci_oe_o, sdr_oe_o, ref_oe_o, apic_oe_o, usb_oe_o, ss_en_o, e);
    end
  endtask

  function automatic logic half_of(input int cnt);
    return (cnt % 2) == 1;
  endfunction

  function automatic logic quarter_of(input int cnt);
    return (cnt > 0) && (((cnt - 1) % 4) < 2);
  endfunction

  // one stimulus step: check outputs of the step two back (R1 latency), then drive
  task automatic step(input logic [3:0] cfg, input logic t);
    logic [8:0] e;
    string tag;
    @(negedge clk);
    if (v2) compare(exp_q2, tag_q2);
    cfg_i  = cfg;
    tclk_i = t;
    cpu_i  = g[0];
    ref_i  = g[1];
    c48_i  = g[0] ^ g[2];
    c24_i  = g[2];
    if (cpu_i && !prev_cpu) n_cpu++;
    prev_cpu = cpu_i;
    if (t && !prev_t) m_t++;
    prev_t = t;
    if (cfg[1:0] == 2'b01 && prev_mode != 2'b01) m_t = 0;  // R11 clear on entry
    prev_mode = cfg[1:0];
    e = '0;
    case (cfg[1:0])
      2'b00, 2'b10: begin  // R5 R6 R7, R4 routes as normal
        e[0] = cpu_i;
        e[2] = cpu_i;
        e[1] = half_of(n_cpu);
        e[3] = ref_i;
        e[4] = ref_i;
        for (int j = 0; j < NU; j++) e[5+j] = cfg[2+j] ? c48_i : c24_i;
        e[7] = 1'b1;
        e[8] = (cfg[1:0] == 2'b10);
        tag = (cfg[1:0] == 2'b10) ? "R4 R5 R6 R7 R3 R1" : "R5 R6 R7 R3 R1";
      end
      2'b01: begin  // R8 R9 R10 R11
        e[3] = t;
        e[4] = t;
        e[0] = half_of(m_t);
        e[2] = half_of(m_t);
        e[1] = quarter_of(m_t);
        for (int j = 0; j < NU; j++) e[5+j] = cfg[2+j] ? half_of(m_t) : quarter_of(m_t);
        e[7] = 1'b1;
        tag = "R8 R9 R10 R11 R7 R3 R1";
      end
      default: tag = "R2 R1";
    endcase
    exp_q2 = exp_q1; tag_q2 = tag_q1; v2 = v1;
    exp_q1 = e;      tag_q1 = tag;    v1 = 1'b1;
    g++;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    n_chk++;
    if ({cpu_clk_o, cpu_oe_o, pci_clk_o, pci_oe_o, sdr_clk_o, sdr_oe_o, ref_clk_o, ref_oe_o,
         apic_clk_o, apic_oe_o, usb_clk_o, usb_oe_o, ss_en_o} != '0) begin
      n_bad++;
      $display("FAIL R12 reset: cpu=%b oe=%b pci=%b sdr=%b ss=%b expected all zero",
               cpu_clk_o, cpu_oe_o, pci_clk_o, sdr_clk_o, ss_en_o);
    end
    rst_n = 1'b1;

    for (int r = 0; r < 8; r++)
      for (int k = 0; k < ROW_STEPS; k++)
        step(ROWS[r], (k == 0) ? 1'b0 : k[0]);

    // R11 re-entry part-way through a divide cycle: leave test after one rise, return, expect cleared phase
    step(4'b0001, 1'b0);
    step(4'b0001, 1'b1);
    step(4'b0001, 1'b1);
    step(4'b0000, 1'b0);
    step(4'b0001, 1'b1);  // rise on the entry step is discarded
    step(4'b0001, 1'b0);
    step(4'b0001, 1'b1);
    step(4'b0001, 1'b0);
    step(4'b0001, 1'b1);
    // R2 high-impedance after test
    step(4'b1111, 1'b0);
    step(4'b1111, 1'b1);
    step(4'b1111, 1'b0);
    step(4'b1111, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R1 watchdog expired: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule